// File: doc/BRIEF.md
# Serial ADC Sampler Driven by a Free-Running Counter

This block drives an 8-bit serial successive-approximation converter that has three wires: an active-low chip select, a conversion clock, and a serial data line. A single 8-bit counter runs freely on the 4 MHz system clock. Every interface signal is decoded from bits of that counter, so the block has no sequencing state machine. Counter bit 3 is the converter clock. It runs at 250 kHz, below the converter's 400 kHz limit. The AND of the two top counter bits forms the chip select, so the converter is deselected for the last quarter of each 256-count frame.

The serial data line is sampled on every falling edge of the converter clock. The sample moves a left-shifting word by one place, and the newest bit enters bit 0. The converter spends one clock on setup and then sends a null bit and eight data bits, most significant bit first. The shift event that closes counter nibble 10 copies the word into a held sample register. At that moment the word holds exactly the eight data bits. The held sample changes once per frame and stays constant between captures. A downstream display path reads it.

Top module: `adc_serial_capture`

## Requirements
- R1: While `rst` is high at a clock edge, the counter, the shift word and `sample` clear to zero. After that edge `adc_sclk` = 0, `adc_cs_n` = 0 and `sample` = 0.
- R2: `adc_sclk` equals bit 3 of the frame count, where the frame count is the number of clock edges since reset, modulo 256. It is low for 8 system clocks and then high for 8.
- R3: `adc_cs_n` is 1 exactly when the frame count is 192 to 255, and 0 for counts 0 to 191.
- R4: At each edge where the frame count before the edge has low nibble 4'hF, `adc_dout` is shifted into bit 0 of the internal word and the older bits move up by one place.
- R5: At the edge where the frame count moves from 8'hAF to 8'hB0, `sample` takes the word as it was before that edge's shift. That word is the `adc_dout` values sampled at counts 8'h2F, 8'h3F, up to 8'h9F. The value sampled at 8'h2F lands in bit 7, and the value sampled at 8'h9F lands in bit 0.
- R6: `sample` changes at no other edge. It keeps its value for the rest of the frame, and it is loaded once per 256-count frame.
- R7: A reset asserted in the middle of a frame restarts the frame at count 0 and clears `sample`. A later capture holds only bits received after the reset.
- R8: The counter wraps from 255 to 0, so `adc_cs_n` falls at count 0 of every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_dout | input | 1 | Serial data from the converter |
| adc_sclk | output | 1 | Conversion clock to the converter (system clock / 16) |
| adc_cs_n | output | 1 | Converter chip select, active low |
| sample | output | 8 | Last complete 8-bit conversion result |

## Verification
The bench goes after the capture boundary. A design that captured one shift too late or too early would drop the most significant bit or take in the null bit, and all-ones, all-zeros and alternating data frames expose that as a shifted word. The bench also checks that `sample` is stable for every other cycle of the frame, which catches a capture strobe that stays on for the whole nibble and reloads sixteen times. A reset placed inside the data window checks that the partial word is discarded and the frame restarts. The bench checks the chip-select edges at counts 192 and 0, where a wrong decode of the top bits would shift the window.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Default geometry of the counter-sequenced converter interface
    parameter int CNT_W_DEF    = 8;   // free-running frame counter width
    parameter int DIV_BIT_DEF  = 3;   // counter bit used as converter clock
    parameter int CS_BITS_DEF  = 2;   // top counter bits ANDed into chip select
    parameter int CAP_SLOT_DEF = 10;  // value of bits above DIV_BIT that captures
    parameter int SAMPLE_W_DEF = 8;   // converter resolution

    // Count at which the capture shift edge occurs (slot followed by all ones)
    function automatic int capture_count(input int slot, input int div_bit);
        return (slot << (div_bit + 1)) | ((1 << (div_bit + 1)) - 1);
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
    import adc_seq_pkg::*;
#(
    parameter int CNT_W    = CNT_W_DEF,
    parameter int DIV_BIT  = DIV_BIT_DEF,
    parameter int CS_BITS  = CS_BITS_DEF,
    parameter int CAP_SLOT = CAP_SLOT_DEF
) (
    input  logic clk,
    input  logic rst,
    output logic sclk,
    output logic cs_n,
    output logic shift_stb,
    output logic cap_stb
);
    localparam int HI_W = CNT_W - DIV_BIT - 1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [HI_W-1:0]  SLOT = HI_W'(CAP_SLOT);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + ONE;
        if (rst) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Falling edge of the divided clock happens when all bits up to DIV_BIT are ones
    assign sclk      = st_q.cnt[DIV_BIT];
    assign cs_n      = &st_q.cnt[CNT_W-1 -: CS_BITS];
    assign shift_stb = &st_q.cnt[DIV_BIT:0];
    assign cap_stb   = shift_stb && (st_q.cnt[CNT_W-1:DIV_BIT+1] == SLOT);

endmodule

// File: rtl/adc_seq_shifter.sv
module adc_seq_shifter
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shift_en,
    input  logic                din,
    output logic [SAMPLE_W-1:0] word
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] sh;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            // first received bit (MSB) migrates toward the top
            st_d.sh = {st_q.sh[SAMPLE_W-2:0], din};
        end
        if (rst) begin
            st_d.sh = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign word = st_q.sh;

endmodule

// File: rtl/adc_seq_hold.sv
module adc_seq_hold
    import adc_seq_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] word,
    output logic [SAMPLE_W-1:0] held
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] val;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.val = word;
        end
        if (rst) begin
            st_d.val = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign held = st_q.val;

endmodule

// File: rtl/adc_serial_capture.sv
module adc_serial_capture
    import adc_seq_pkg::*;
#(
    parameter int CNT_W    = CNT_W_DEF,
    parameter int DIV_BIT  = DIV_BIT_DEF,
    parameter int CS_BITS  = CS_BITS_DEF,
    parameter int CAP_SLOT = CAP_SLOT_DEF,
    parameter int SAMPLE_W = SAMPLE_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                adc_dout,
    output logic                adc_sclk,
    output logic                adc_cs_n,
    output logic [SAMPLE_W-1:0] sample
);
    logic                shift_stb;
    logic                cap_stb;
    logic [SAMPLE_W-1:0] shift_word;

    adc_seq_timer #(
        .CNT_W    (CNT_W),
        .DIV_BIT  (DIV_BIT),
        .CS_BITS  (CS_BITS),
        .CAP_SLOT (CAP_SLOT)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .sclk      (adc_sclk),
        .cs_n      (adc_cs_n),
        .shift_stb (shift_stb),
        .cap_stb   (cap_stb)
    );

    adc_seq_shifter #(
        .SAMPLE_W (SAMPLE_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_stb),
        .din      (adc_dout),
        .word     (shift_word)
    );

    // Same edge: hold takes the pre-shift word, so null bit is already out
    adc_seq_hold #(
        .SAMPLE_W (SAMPLE_W)
    ) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (cap_stb),
        .word (shift_word),
        .held (sample)
    );

endmodule

// File: rtl/adc_serial_capture_chk.sv
module adc_serial_capture_chk
    import adc_seq_pkg::*;
#(
    parameter int CNT_W    = CNT_W_DEF,
    parameter int DIV_BIT  = DIV_BIT_DEF,
    parameter int CS_BITS  = CS_BITS_DEF,
    parameter int CAP_SLOT = CAP_SLOT_DEF,
    parameter int SAMPLE_W = SAMPLE_W_DEF
) (
    input logic                clk,
    input logic                rst,
    input logic                adc_dout,
    input logic                adc_sclk,
    input logic                adc_cs_n,
    input logic [SAMPLE_W-1:0] sample,
    input logic [SAMPLE_W-1:0] shift_word
);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
    localparam logic [CNT_W-1:0] CAP_CNT   = CNT_W'(capture_count(CAP_SLOT, DIV_BIT));
    localparam logic [CNT_W-1:0] CAP_AFTER = CAP_CNT + ONE;
    localparam logic [CNT_W-1:0] CS_START  = ~(({CNT_W{1'b1}}) >> CS_BITS);

    // Independent edge count since reset
    logic [CNT_W-1:0] ref_cnt;
    always_ff @(posedge clk) begin
        if (rst) ref_cnt <= '0;
        else     ref_cnt <= ref_cnt + ONE;
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sample == '0 && !adc_sclk && !adc_cs_n));

    assert_sclk_phase_R2: assert property (@(posedge clk) disable iff (rst)
        adc_sclk == ref_cnt[DIV_BIT]);

    assert_cs_window_R3: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n == (ref_cnt >= CS_START));

    assert_shift_in_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (&$past(ref_cnt[DIV_BIT:0])))
            |-> (shift_word[0] == $past(adc_dout)));

    assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ref_cnt == CAP_AFTER) |-> (sample == $past(shift_word)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ref_cnt != CAP_AFTER) |-> $stable(sample));

    assert_wrap_cs_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ref_cnt == '0) |-> $fell(adc_cs_n));

endmodule

bind adc_serial_capture adc_serial_capture_chk #(
    .CNT_W    (CNT_W),
    .DIV_BIT  (DIV_BIT),
    .CS_BITS  (CS_BITS),
    .CAP_SLOT (CAP_SLOT),
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .adc_dout   (adc_dout),
    .adc_sclk   (adc_sclk),
    .adc_cs_n   (adc_cs_n),
    .sample     (sample),
    .shift_word (shift_word)
);

// File: tb/adc_serial_capture_tb.sv
`timescale 1ns/1ps
module adc_serial_capture_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adc_dout = 1'b0;
    logic       adc_sclk;
    logic       adc_cs_n;
    logic [7:0] sample;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    adc_serial_capture u_dut (
        .clk      (clk),
        .rst      (rst),
        .adc_dout (adc_dout),
        .adc_sclk (adc_sclk),
        .adc_cs_n (adc_cs_n),
        .sample   (sample)
    );

    // Reference model built from the requirements
    logic [7:0] m_cnt = 8'h00;
    logic [7:0] m_word = 8'h00;
    logic [7:0] m_sample = 8'h00;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 8'h00; m_word = 8'h00; m_sample = 8'h00;
        end else begin
            if (m_cnt[3:0] == 4'hF) begin
                if (m_cnt == 8'hAF) m_sample = m_word;
                m_word = {m_word[6:0], adc_dout};
            end
            m_cnt = m_cnt + 8'd1;
        end
    end

    function automatic logic exp_sclk(input logic [7:0] c);
        return c[3];
    endfunction

    function automatic logic exp_cs_n(input logic [7:0] c);
        return (c >= 8'd192);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s count=%0d actual=%0h expected=%0h", req, m_cnt, act, exp);
        end
    endtask

    // Checks made at the falling edge, after outputs settled from the rising edge
    task automatic check_cycle(input bit after_reset);
        check("R2 sclk", {31'd0, adc_sclk}, {31'd0, exp_sclk(m_cnt)});
        check("R3 cs_n", {31'd0, adc_cs_n}, {31'd0, exp_cs_n(m_cnt)});
        if (m_cnt == 8'hB0 && !after_reset)
            check("R5 R4 capture", {24'd0, sample}, {24'd0, m_sample});
        else
            check("R6 hold", {24'd0, sample}, {24'd0, m_sample});
        if (m_cnt == 8'h00 && !after_reset)
            check("R8 wrap cs", {31'd0, adc_cs_n}, 32'd0);
    endtask

    // Data patterns: 0 random, 1 ones, 2 zeros, 3 alternating per converter bit
    function automatic logic pat_bit(input int mode, input logic [7:0] c);
        case (mode)
            1:       return 1'b1;
            2:       return 1'b0;
            3:       return c[4];
            default: return 1'($urandom);
        endcase
    endfunction

    task automatic run_frames(input int n, input int fixed_mode);
        for (int f = 0; f < n; f++) begin
            int mode;
            mode = (fixed_mode >= 0) ? fixed_mode : int'($urandom_range(0, 3));
            for (int k = 0; k < 256; k++) begin
                @(negedge clk);
                check_cycle(1'b0);
                adc_dout = pat_bit(mode, m_cnt);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: state held in reset
        check("R1 sample", {24'd0, sample}, 32'd0);
        check("R1 sclk", {31'd0, adc_sclk}, 32'd0);
        check("R1 cs_n", {31'd0, adc_cs_n}, 32'd0);
        rst = 1'b0;

        // Directed corner patterns, then random mix
        run_frames(2, 1);
        run_frames(2, 2);
        run_frames(2, 3);
        run_frames(12, -1);

        // R7: reset in the middle of the data window
        begin
            int stop_at;
            stop_at = int'($urandom_range(8'h40, 8'h9E));
            while (int'(m_cnt) != stop_at) begin
                @(negedge clk);
                check_cycle(1'b0);
                adc_dout = 1'($urandom);
            end
        end
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R7 sample cleared", {24'd0, sample}, 32'd0);
        check("R7 count restart sclk", {31'd0, adc_sclk}, 32'd0);
        check("R7 count restart cs_n", {31'd0, adc_cs_n}, 32'd0);
        adc_dout = 1'b1;
        begin
            bit first;
            first = 1'b1;
            for (int k = 0; k < 256; k++) begin
                @(negedge clk);
                check_cycle(first);
                first = 1'b0;
                adc_dout = pat_bit(3, m_cnt);
            end
        end
        run_frames(4, -1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule